// File: doc/BRIEF.md
# Physical Memory Protection Permission Checker

This block decides whether one memory access may proceed under a table of protection entries. Each entry arrives already decoded. It has an inclusive address range, a low bound and a high bound, plus a configuration byte with read, write and execute grants, a lock bit and a matching-mode field. Two security control bits also arrive as inputs. One selects a stricter lockdown interpretation of the entries. The other turns the no-match case into deny-all. The block stores no entries itself: the register file that owns the entries drives them as flat vectors.

An access is described by its start address, its size in bytes (1 to 8), the permissions it requests and whether it runs in machine mode or in a lower mode. The block scans the entries from the lowest index and resolves which entry governs the access. It then computes the allowed permission set and reports whether the request fits inside that set. Results appear on registered outputs one cycle after a request strobe.

Top module: `pmpchk_top`

## Requirements
- R1: A result is registered on the rising edge that samples `req_valid` high, and `rsp_valid` is high in exactly the cycle that follows each strobed cycle. Response fields change only on strobed edges.
- R2: The last byte of an access is `req_addr + req_size - 1`. The winning entry is the lowest-index active entry whose inclusive range `[lo, hi]` contains both the first and the last byte. It is reported with `rsp_hit=1` and its index on `rsp_idx`.
- R3: An entry whose mode field (configuration bits 4:3) is zero is inactive. It is skipped for matching and for overlap detection.
- R4: The scan may first reach an active entry that contains exactly one of the first and last bytes. In that case the access gets no permissions, `rsp_hit=0` and `rsp_default=0`, and no higher-index entry is considered.
- R5: With lockdown clear, a matched entry gives R, W and X to a machine-mode access when its lock bit (configuration bit 7) is 0. Otherwise it gives its own grant bits: R in bit 0, W in bit 1, X in bit 2.
- R6: With lockdown set, a machine-mode access on a matched entry is granted by the code {L,R,W,X}. Codes 2, 3 and 14 give RW. Codes 9 and 10 give X. Codes 11 and 13 give RX. Codes 12 and 15 give R. All other codes give nothing.
- R7: With lockdown set, a lower-mode access on a matched entry is granted by the code {L,R,W,X}. Code 7 gives RWX. Code 5 gives RX. Codes 3 and 6 give RW. Codes 2, 4 and 15 give R. Codes 1, 10 and 11 give X. All other codes give nothing.
- R8: When no entry matches and no partial overlap was found, `rsp_default=1`. If the deny-all bit is set, nothing is granted in either mode.
- R9: In the default case with deny-all clear and lockdown set, a machine-mode access that does not request X is granted RW. Every other access is granted nothing.
- R10: In the default case with both security bits clear, machine mode is granted RWX and a lower mode is granted nothing.
- R11: `rsp_allow` uses bit 0 for R, bit 1 for W and bit 2 for X. `req_rwx` uses the same encoding. `rsp_deny` is 1 exactly when a requested bit is missing from `rsp_allow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe |
| req_addr | input | ADDR_W | First byte address |
| req_size | input | 4 | Access size in bytes, 1 to 8 |
| req_rwx | input | 3 | Requested permissions (R bit 0, W bit 1, X bit 2) |
| req_mmode | input | 1 | 1 for machine mode, 0 for a lower mode |
| ent_lo | input | N_ENT*ADDR_W | Inclusive low bound per entry, entry i at bits [i*ADDR_W +: ADDR_W] |
| ent_hi | input | N_ENT*ADDR_W | Inclusive high bound per entry |
| ent_cfg | input | N_ENT*8 | Configuration byte per entry |
| sec_lockdown | input | 1 | Strict lockdown interpretation |
| sec_denyall | input | 1 | Deny everything when no entry matches |
| rsp_valid | output | 1 | Result valid |
| rsp_allow | output | 3 | Allowed permissions |
| rsp_hit | output | 1 | An entry matched |
| rsp_idx | output | IDX_W | Index of the matching entry |
| rsp_default | output | 1 | Default policy applied |
| rsp_deny | output | 1 | Request not covered by the allowed set |

## Verification
Some properties are checked by assertions on every cycle. The response follows the strobe by exactly one cycle. A hit and a default are never reported together. The deny flag always agrees with the previous request against the granted set. An overlap result carries no permissions. Default results grant nothing to lower modes and nothing at all under deny-all. The lockdown machine-mode table never grants W together with X.

Other behaviour can only be shown by the bench's scenarios. These include which entry wins under priority, that inactive entries are skipped, and that an overlap stops the scan before a later full match. They also include the exact contents of both 16-row lockdown tables and of each default branch.

// File: rtl/pmpchk_pkg.sv
package pmpchk_pkg;

  localparam int CFG_R    = 0;
  localparam int CFG_W    = 1;
  localparam int CFG_X    = 2;
  localparam int CFG_MLO  = 3;
  localparam int CFG_MHI  = 4;
  localparam int CFG_LOCK = 7;

  typedef logic [2:0] perm_t;

  localparam perm_t PERM_NONE = 3'b000;
  localparam perm_t PERM_R    = 3'b001;
  localparam perm_t PERM_RW   = 3'b011;
  localparam perm_t PERM_X    = 3'b100;
  localparam perm_t PERM_RX   = 3'b101;
  localparam perm_t PERM_RWX  = 3'b111;

  // Lockdown grants for machine mode, code = {L,R,W,X}
  function automatic perm_t lockdown_mach(input logic [3:0] code);
    perm_t p;
    unique case (code)
      4'd2, 4'd3, 4'd14: p = PERM_RW;
      4'd9, 4'd10:       p = PERM_X;
      4'd11, 4'd13:      p = PERM_RX;
      4'd12, 4'd15:      p = PERM_R;
      default:           p = PERM_NONE;
    endcase
    return p;
  endfunction

  // Lockdown grants for lower modes, code = {L,R,W,X}
  function automatic perm_t lockdown_user(input logic [3:0] code);
    perm_t p;
    unique case (code)
      4'd7:               p = PERM_RWX;
      4'd5:               p = PERM_RX;
      4'd3, 4'd6:         p = PERM_RW;
      4'd2, 4'd4, 4'd15:  p = PERM_R;
      4'd1, 4'd10, 4'd11: p = PERM_X;
      default:            p = PERM_NONE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/pmpchk_range.sv
module pmpchk_range #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] first_b,
  input  logic [ADDR_W-1:0] last_b,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [1:0]        mode,
  output logic              full,
  output logic              partial
);
  logic active;
  logic in_first;
  logic in_last;

  always_comb begin
    active   = (mode != 2'b00);
    in_first = (first_b >= lo) && (first_b <= hi);
    in_last  = (last_b  >= lo) && (last_b  <= hi);
    full     = active && in_first && in_last;
    partial  = active && (in_first ^ in_last);
  end
endmodule

// File: rtl/pmpchk_select.sv
module pmpchk_select #(
  parameter int N_ENT = 8,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0] full,
  input  logic [N_ENT-1:0] partial,
  output logic             found,
  output logic             overlap,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found   = 1'b0;
    overlap = 1'b0;
    idx     = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!found && !overlap) begin
        if (full[i]) begin
          found = 1'b1;
          idx   = IDX_W'(i);
        end else if (partial[i]) begin
          overlap = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pmpchk_perm.sv
module pmpchk_perm
  import pmpchk_pkg::*;
(
  input  logic  found,
  input  logic  overlap,
  input  logic  lock,
  input  perm_t grant,
  input  logic  mmode,
  input  logic  want_x,
  input  logic  lockdown,
  input  logic  denyall,
  output perm_t allow,
  output logic  use_default
);
  logic [3:0] code;
  perm_t      hit_perm;
  perm_t      dflt_perm;

  always_comb begin
    code = {lock, grant[CFG_R], grant[CFG_W], grant[CFG_X]};
    if (!lockdown) begin
      hit_perm = (mmode && !lock) ? PERM_RWX : grant;
    end else if (mmode) begin
      hit_perm = lockdown_mach(code);
    end else begin
      hit_perm = lockdown_user(code);
    end

    if (denyall) begin
      dflt_perm = PERM_NONE;
    end else if (lockdown) begin
      dflt_perm = (mmode && !want_x) ? PERM_RW : PERM_NONE;
    end else begin
      dflt_perm = mmode ? PERM_RWX : PERM_NONE;
    end

    use_default = !found && !overlap;
    if (found) begin
      allow = hit_perm;
    end else if (overlap) begin
      allow = PERM_NONE;
    end else begin
      allow = dflt_perm;
    end
  end
endmodule

// File: rtl/pmpchk_top.sv
module pmpchk_top
  import pmpchk_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [3:0]              req_size,
  input  logic [2:0]              req_rwx,
  input  logic                    req_mmode,
  input  logic [N_ENT*ADDR_W-1:0] ent_lo,
  input  logic [N_ENT*ADDR_W-1:0] ent_hi,
  input  logic [N_ENT*8-1:0]      ent_cfg,
  input  logic                    sec_lockdown,
  input  logic                    sec_denyall,
  output logic                    rsp_valid,
  output logic [2:0]              rsp_allow,
  output logic                    rsp_hit,
  output logic [IDX_W-1:0]        rsp_idx,
  output logic                    rsp_default,
  output logic                    rsp_deny
);
  logic [ADDR_W-1:0] last_b;
  logic [N_ENT-1:0]  full;
  logic [N_ENT-1:0]  partial;
  logic [N_ENT-1:0]  rsvd_bits;
  logic              found;
  logic              overlap;
  logic [IDX_W-1:0]  sel_idx;
  logic [7:0]        sel_cfg;
  perm_t             allow_c;
  logic              dflt_c;
  logic              deny_c;
  logic              unused_rsvd;

  assign last_b = req_addr + ADDR_W'(req_size) - ADDR_W'(1);

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    pmpchk_range #(.ADDR_W(ADDR_W)) u_range (
      .first_b (req_addr),
      .last_b  (last_b),
      .lo      (ent_lo[g*ADDR_W +: ADDR_W]),
      .hi      (ent_hi[g*ADDR_W +: ADDR_W]),
      .mode    (ent_cfg[g*8+CFG_MLO +: 2]),
      .full    (full[g]),
      .partial (partial[g])
    );
    assign rsvd_bits[g] = ^ent_cfg[g*8+5 +: 2];
  end

  assign unused_rsvd = ^rsvd_bits;

  pmpchk_select #(.N_ENT(N_ENT)) u_select (
    .full    (full),
    .partial (partial),
    .found   (found),
    .overlap (overlap),
    .idx     (sel_idx)
  );

  always_comb begin
    sel_cfg = ent_cfg[sel_idx*8 +: 8];
  end

  pmpchk_perm u_perm (
    .found       (found),
    .overlap     (overlap),
    .lock        (sel_cfg[CFG_LOCK]),
    .grant       (sel_cfg[2:0]),
    .mmode       (req_mmode),
    .want_x      (req_rwx[CFG_X]),
    .lockdown    (sec_lockdown),
    .denyall     (sec_denyall),
    .allow       (allow_c),
    .use_default (dflt_c)
  );

  always_comb begin
    deny_c = |(req_rwx & ~allow_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_allow   <= '0;
      rsp_hit     <= 1'b0;
      rsp_idx     <= '0;
      rsp_default <= 1'b0;
      rsp_deny    <= 1'b0;
    end else if (req_valid) begin
      rsp_allow   <= allow_c;
      rsp_hit     <= found;
      rsp_idx     <= found ? sel_idx : '0;
      rsp_default <= dflt_c;
      rsp_deny    <= deny_c;
    end
  end
endmodule

// File: rtl/pmpchk_sva.sv
module pmpchk_sva #(
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [ADDR_W-1:0]       req_addr,
  input logic [3:0]              req_size,
  input logic [2:0]              req_rwx,
  input logic                    req_mmode,
  input logic [N_ENT*ADDR_W-1:0] ent_lo,
  input logic [N_ENT*ADDR_W-1:0] ent_hi,
  input logic [N_ENT*8-1:0]      ent_cfg,
  input logic                    sec_lockdown,
  input logic                    sec_denyall,
  input logic                    rsp_valid,
  input logic [2:0]              rsp_allow,
  input logic                    rsp_hit,
  input logic [IDX_W-1:0]        rsp_idx,
  input logic                    rsp_default,
  input logic                    rsp_deny
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_allow) && $stable(rsp_deny));

  p_hit_xor_default_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_default));

  p_overlap_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit && !rsp_default |-> rsp_allow == 3'b000);

  p_mach_no_wx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit && $past(sec_lockdown) && $past(req_mmode)
      |-> rsp_allow != 3'b111);

  p_denyall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_default && $past(sec_denyall) |-> rsp_allow == 3'b000);

  p_lower_default_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_default && !$past(req_mmode) |-> rsp_allow == 3'b000);

  p_deny_subset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_deny == (|($past(req_rwx) & ~rsp_allow)));
endmodule

bind pmpchk_top pmpchk_sva #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/pmpchk_top_tb.sv
module pmpchk_top_tb;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int IW = 3;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [3:0]    req_size;
  logic [2:0]    req_rwx;
  logic          req_mmode;
  logic [N*AW-1:0] ent_lo;
  logic [N*AW-1:0] ent_hi;
  logic [N*8-1:0]  ent_cfg;
  logic          sec_lockdown;
  logic          sec_denyall;
  logic          rsp_valid;
  logic [2:0]    rsp_allow;
  logic          rsp_hit;
  logic [IW-1:0] rsp_idx;
  logic          rsp_default;
  logic          rsp_deny;

  logic [AW-1:0] lo_a [N];
  logic [AW-1:0] hi_a [N];
  logic [7:0]    cfg_a [N];

  int errors = 0;
  int checks = 0;

  // expected lockdown grants, R=1 W=2 X=4
  int exp_mach [16] = '{0,0,3,3,0,0,0,0,0,4,4,5,1,5,3,1};
  int exp_user [16] = '{0,4,1,3,1,5,3,7,0,0,4,4,0,0,0,1};

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_lo[i*AW +: AW] = lo_a[i];
      ent_hi[i*AW +: AW] = hi_a[i];
      ent_cfg[i*8 +: 8]  = cfg_a[i];
    end
  end

  pmpchk_top #(.N_ENT(N), .ADDR_W(AW)) u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      lo_a[i] = '0; hi_a[i] = '0; cfg_a[i] = 8'h00;
    end
    sec_lockdown = 1'b0;
    sec_denyall  = 1'b0;
  endtask

  // cfg layout: R bit0, W bit1, X bit2, mode bits 4:3, lock bit7
  function automatic logic [7:0] mk_cfg(input logic l, input logic [2:0] rwx);
    return {l, 2'b00, 2'b01, rwx};
  endfunction

  task automatic access(input logic [AW-1:0] a, input logic [3:0] sz,
                        input logic [2:0] rwx, input logic m);
    @(negedge clk);
    req_addr = a; req_size = sz; req_rwx = rwx; req_mmode = m;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset valid", int'(rsp_valid), 0);
    check("R1 reset allow", int'(rsp_allow), 0);
  endtask

  task automatic t_timing();
    clear_all();
    access(32'h100, 4'd1, 3'b001, 1'b1);
    check("R1 valid after strobe", int'(rsp_valid), 1);
    @(negedge clk);
    check("R1 valid drops", int'(rsp_valid), 0);
    check("R1 allow held", int'(rsp_allow), 7);
  endtask

  task automatic t_priority();
    clear_all();
    lo_a[0] = 32'h1000; hi_a[0] = 32'h1FFF; cfg_a[0] = mk_cfg(1'b0, 3'b001);
    lo_a[1] = 32'h1000; hi_a[1] = 32'h10FF; cfg_a[1] = mk_cfg(1'b0, 3'b111);
    access(32'h1010, 4'd4, 3'b001, 1'b0);
    check("R2 hit", int'(rsp_hit), 1);
    check("R2 lowest idx", int'(rsp_idx), 0);
    check("R2 allow", int'(rsp_allow), 1);
    cfg_a[0] = 8'h07;
    access(32'h1010, 4'd4, 3'b001, 1'b0);
    check("R3 inactive skipped idx", int'(rsp_idx), 1);
    check("R3 allow of entry1", int'(rsp_allow), 7);
    access(32'h1FF9, 4'd8, 3'b001, 1'b0);
    check("R3 only inactive plus active0 miss", int'(rsp_default), 1);
  endtask

  task automatic t_partial();
    clear_all();
    lo_a[2] = 32'h2000; hi_a[2] = 32'h2007; cfg_a[2] = mk_cfg(1'b0, 3'b011);
    lo_a[3] = 32'h2000; hi_a[3] = 32'h20FF; cfg_a[3] = mk_cfg(1'b0, 3'b111);
    access(32'h2004, 4'd8, 3'b001, 1'b0);
    check("R4 overlap allow", int'(rsp_allow), 0);
    check("R4 overlap hit", int'(rsp_hit), 0);
    check("R4 overlap default", int'(rsp_default), 0);
    check("R4 overlap deny", int'(rsp_deny), 1);
    access(32'h2000, 4'd8, 3'b011, 1'b0);
    check("R2 exact fit last byte", int'(rsp_idx), 2);
    check("R2 exact fit allow", int'(rsp_allow), 3);
  endtask

  task automatic t_legacy();
    clear_all();
    lo_a[4] = 32'h3000; hi_a[4] = 32'h30FF; cfg_a[4] = mk_cfg(1'b0, 3'b001);
    access(32'h3000, 4'd4, 3'b100, 1'b1);
    check("R5 machine unlocked", int'(rsp_allow), 7);
    access(32'h3000, 4'd4, 3'b100, 1'b0);
    check("R5 lower unlocked", int'(rsp_allow), 1);
    cfg_a[4] = mk_cfg(1'b1, 3'b001);
    access(32'h3000, 4'd4, 3'b100, 1'b1);
    check("R5 machine locked", int'(rsp_allow), 1);
  endtask

  task automatic t_lockdown_tables();
    clear_all();
    sec_lockdown = 1'b1;
    lo_a[0] = 32'h4000; hi_a[0] = 32'h4FFF;
    for (int c = 0; c < 16; c++) begin
      cfg_a[0] = mk_cfg(c[3], {c[0], c[1], c[2]});
      access(32'h4100, 4'd2, 3'b000, 1'b1);
      check($sformatf("R6 code %0d", c), int'(rsp_allow), exp_mach[c]);
      access(32'h4100, 4'd2, 3'b000, 1'b0);
      check($sformatf("R7 code %0d", c), int'(rsp_allow), exp_user[c]);
    end
  endtask

  task automatic t_default();
    clear_all();
    lo_a[0] = 32'h5000; hi_a[0] = 32'h50FF; cfg_a[0] = mk_cfg(1'b0, 3'b111);
    access(32'h9000, 4'd4, 3'b001, 1'b1);
    check("R10 default flag", int'(rsp_default), 1);
    check("R10 machine default", int'(rsp_allow), 7);
    access(32'h9000, 4'd4, 3'b001, 1'b0);
    check("R10 lower default", int'(rsp_allow), 0);
    sec_lockdown = 1'b1;
    access(32'h9000, 4'd4, 3'b011, 1'b1);
    check("R9 machine no X", int'(rsp_allow), 3);
    access(32'h9000, 4'd4, 3'b101, 1'b1);
    check("R9 machine with X", int'(rsp_allow), 0);
    sec_denyall = 1'b1;
    access(32'h9000, 4'd4, 3'b001, 1'b1);
    check("R8 denyall machine", int'(rsp_allow), 0);
    check("R8 default flag", int'(rsp_default), 1);
    sec_lockdown = 1'b0;
    access(32'h9000, 4'd4, 3'b001, 1'b1);
    check("R8 denyall no lockdown", int'(rsp_allow), 0);
  endtask

  task automatic t_deny();
    clear_all();
    lo_a[1] = 32'h6000; hi_a[1] = 32'h60FF; cfg_a[1] = mk_cfg(1'b0, 3'b001);
    access(32'h6000, 4'd4, 3'b010, 1'b0);
    check("R11 write on read-only", int'(rsp_deny), 1);
    access(32'h6000, 4'd4, 3'b001, 1'b0);
    check("R11 read allowed", int'(rsp_deny), 0);
    cfg_a[1] = mk_cfg(1'b0, 3'b101);
    access(32'h6000, 4'd4, 3'b101, 1'b0);
    check("R11 RX subset", int'(rsp_deny), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_size = 4'd1; req_rwx = '0; req_mmode = 1'b0;
    clear_all();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_timing();
    t_priority();
    t_partial();
    t_legacy();
    t_lockdown_tables();
    t_default();
    t_deny();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule